// File: doc/BRIEF.md
# Indirect Video Memory Access Port with Signed Stride

This block gives a processor indirect access to a word-wide video memory through a small window of three registers: a pointer, a data port and a signed stride. The processor loads the pointer, optionally loads the stride, and then streams words through the data port. Each accepted data write stores one word at the pointer and moves the pointer forward by the stride, wrapping within the memory's address space. A run of columns, rows or any regular pattern of cells can be filled without reloading the pointer.

Reads through the pointer or data register return the memory word at the pointer and leave the pointer where it is. Reads through the stride register return the stride. Read data comes back one cycle after the request, together with a valid strobe. The memory itself sits outside the block and is reached through a plain synchronous single-port interface: address, write data, write enable and read data with one cycle of read latency.

Byte accesses follow a fixed rule. A byte write on the even (high) lane copies that byte into both halves of the target register, and a write that only enables the odd (low) lane is dropped.

Top module: `vram_port`

## Requirements
- R1: After reset the pointer is 0 (seen on `vram_addr`), the stride is 0 and `bus_rvalid` is low.
- R2: A write with `bus_reg` = 0 (pointer register) and `bus_be` = 2'b11 loads `bus_wdata` into the pointer; `vram_addr` shows the new value from the next cycle.
- R3: A write with `bus_reg` = 1 (data port) drives `vram_we` high in the same cycle with `vram_addr` equal to the current pointer and `vram_wdata` equal to the written word; in the next cycle the pointer equals the old pointer plus the stride.
- R4: A read with `bus_reg` = 0 or 1 returns on `bus_rdata` the memory word at the current pointer, and the pointer does not change.
- R5: A write with `bus_reg` = 2 sets the stride; a read with `bus_reg` = 2 returns the stride.
- R6: A write with `bus_be` = 2'b10 (even byte only, data taken from `bus_wdata[15:8]`) stores that byte into both halves of the pointer, data or stride register; for the data port `vram_wdata` carries the doubled byte.
- R7: A write with `bus_be` = 2'b01 (odd byte only) or 2'b00 changes nothing: no memory write, the pointer and the stride keep their values.
- R8: Consecutive data writes on back-to-back cycles each use the pointer already advanced by the previous write.
- R9: The stride is a signed 16-bit value and the pointer wraps modulo 2^16, both below 0 and above 0xFFFF.
- R10: `bus_reg` = 3 is unmapped: writes to it change nothing and reads from it return 0.
- R11: `bus_rvalid` is high exactly in the cycle after a read request, with `bus_rdata` valid in that cycle; writes never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_reg | input | 2 | Register index: 0 pointer, 1 data port, 2 stride, 3 unmapped |
| bus_be | input | 2 | Byte lanes: bit 1 even (high) byte, bit 0 odd (low) byte |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| vram_addr | output | ADDR_W | Memory address, equal to the pointer |
| vram_wdata | output | DATA_W | Memory write data |
| vram_we | output | 1 | Memory write enable |
| vram_rdata | input | DATA_W | Memory read data, one cycle after the address |

## Verification
Directed sequences come first. Positive, negative and zero strides decide whether the stride is treated as signed and whether the pointer wraps at both ends. Back-to-back data writes followed by single reads show whether each write used the freshly advanced pointer or a stale one. Full-word, even-byte, odd-byte and no-lane writes to every register separate doubling from masking and from dropping. A long seeded random mix of reads and writes over all registers and lanes, kept to a small address window, then compares every read against a reference memory, so that writes landing on the wrong cell or with the wrong width show up later as bad read data.

// File: rtl/vport_pkg.sv
`timescale 1ns/1ps
package vport_pkg;

  // Register index within the port window (byte offsets 0, 2, 4, 6)
  typedef enum logic [1:0] {
    REG_PTR    = 2'd0,
    REG_DATA   = 2'd1,
    REG_STRIDE = 2'd2,
    REG_NONE   = 2'd3
  } vport_reg_e;

  // Where a returning read word comes from
  typedef enum logic [1:0] {
    SRC_VRAM   = 2'd0,
    SRC_STRIDE = 2'd1,
    SRC_ZERO   = 2'd2
  } vport_src_e;

  // Byte lane enable codes
  localparam logic [1:0] BE_WORD = 2'b11;
  localparam logic [1:0] BE_EVEN = 2'b10;

endpackage

// File: rtl/vport_decode.sv
`timescale 1ns/1ps
module vport_decode
  import vport_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              req,
  input  logic              we,
  input  logic [1:0]        reg_sel,
  input  logic [1:0]        be,
  input  logic [DATA_W-1:0] wdata,
  output logic              set_ptr,
  output logic              set_stride,
  output logic              wr_data,
  output logic              rd_any,
  output vport_src_e        rd_src,
  output logic [DATA_W-1:0] wword
);
  localparam int BYTE_W = DATA_W / 2;
  localparam int LANES  = 2;

  logic [DATA_W-1:0] doubled;
  logic              lane_ok;
  logic              wr_ok;
  vport_reg_e        rsel;

  // Even (high) byte copied into every lane
  for (genvar g = 0; g < LANES; g++) begin : g_dup
    assign doubled[g*BYTE_W +: BYTE_W] = wdata[DATA_W-1 -: BYTE_W];
  end

  always_comb begin
    rsel    = vport_reg_e'(reg_sel);
    lane_ok = (be == BE_WORD) || (be == BE_EVEN);
    wr_ok   = req && we && lane_ok;
    wword   = (be == BE_WORD) ? wdata : doubled;

    set_ptr    = wr_ok && (rsel == REG_PTR);
    wr_data    = wr_ok && (rsel == REG_DATA);
    set_stride = wr_ok && (rsel == REG_STRIDE);

    rd_any = req && !we;
    unique case (rsel)
      REG_PTR, REG_DATA: rd_src = SRC_VRAM;
      REG_STRIDE:        rd_src = SRC_STRIDE;
      default:           rd_src = SRC_ZERO;
    endcase
  end

endmodule

// File: rtl/vport_regs.sv
`timescale 1ns/1ps
module vport_regs #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_ptr,
  input  logic              set_stride,
  input  logic              wr_data,
  input  logic [DATA_W-1:0] wword,
  output logic [ADDR_W-1:0] ptr_q,
  output logic [DATA_W-1:0] stride_q
);
  logic [ADDR_W-1:0] ptr_load;
  logic [ADDR_W-1:0] step;

  // Fit the data word and the signed stride to the address width
  if (ADDR_W <= DATA_W) begin : g_narrow
    assign ptr_load = wword[ADDR_W-1:0];
    assign step     = stride_q[ADDR_W-1:0];
  end else begin : g_wide
    assign ptr_load = {{(ADDR_W-DATA_W){1'b0}}, wword};
    assign step     = {{(ADDR_W-DATA_W){stride_q[DATA_W-1]}}, stride_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q    <= '0;
      stride_q <= '0;
    end else begin
      if (set_ptr)
        ptr_q <= ptr_load;
      else if (wr_data)
        ptr_q <= ptr_q + step;
      if (set_stride)
        stride_q <= wword;
    end
  end

  // R3 / R8 / R9: a data write moves the pointer by the stride held at that time
  assert_ptr_advance_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_data && !set_ptr) |=> ptr_q == ADDR_W'($past(ptr_q) + $past(step)));

  // R4 / R7: no pointer or data write leaves the pointer untouched
  assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!set_ptr && !wr_data) |=> $stable(ptr_q));

  // R5 / R7: the stride only moves on a stride write
  assert_stride_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !set_stride |=> $stable(stride_q));

endmodule

// File: rtl/vport_rdpath.sv
`timescale 1ns/1ps
module vport_rdpath
  import vport_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_any,
  input  vport_src_e        rd_src,
  input  logic [DATA_W-1:0] stride_q,
  input  logic [DATA_W-1:0] vram_rdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  vport_src_e        src_q;
  logic [DATA_W-1:0] stride_snap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid        <= 1'b0;
      src_q         <= SRC_ZERO;
      stride_snap_q <= '0;
    end else begin
      rvalid <= rd_any;
      if (rd_any) begin
        src_q         <= rd_src;
        stride_snap_q <= stride_q;
      end
    end
  end

  // Memory output register already holds the word for the request cycle
  always_comb begin
    unique case (src_q)
      SRC_VRAM:   rdata = vram_rdata;
      SRC_STRIDE: rdata = stride_snap_q;
      default:    rdata = '0;
    endcase
  end

  // R10: unmapped reads return zero
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (rvalid && src_q == SRC_ZERO) |-> rdata == '0);

endmodule

// File: rtl/vram_port.sv
`timescale 1ns/1ps
module vram_port
  import vport_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [1:0]        bus_reg,
  input  logic [1:0]        bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic [ADDR_W-1:0] vram_addr,
  output logic [DATA_W-1:0] vram_wdata,
  output logic              vram_we,
  input  logic [DATA_W-1:0] vram_rdata
);
  localparam int BYTE_W = DATA_W / 2;

  logic              set_ptr;
  logic              set_stride;
  logic              wr_data;
  logic              rd_any;
  vport_src_e        rd_src;
  logic [DATA_W-1:0] wword;
  logic [ADDR_W-1:0] ptr_q;
  logic [DATA_W-1:0] stride_q;

  vport_decode #(.DATA_W(DATA_W)) u_decode (
    .req        (bus_req),
    .we         (bus_we),
    .reg_sel    (bus_reg),
    .be         (bus_be),
    .wdata      (bus_wdata),
    .set_ptr    (set_ptr),
    .set_stride (set_stride),
    .wr_data    (wr_data),
    .rd_any     (rd_any),
    .rd_src     (rd_src),
    .wword      (wword)
  );

  vport_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .set_ptr    (set_ptr),
    .set_stride (set_stride),
    .wr_data    (wr_data),
    .wword      (wword),
    .ptr_q      (ptr_q),
    .stride_q   (stride_q)
  );

  vport_rdpath #(.DATA_W(DATA_W)) u_rdpath (
    .clk        (clk),
    .rst        (rst),
    .rd_any     (rd_any),
    .rd_src     (rd_src),
    .stride_q   (stride_q),
    .vram_rdata (vram_rdata),
    .rdata      (bus_rdata),
    .rvalid     (bus_rvalid)
  );

  assign vram_addr  = ptr_q;
  assign vram_we    = wr_data;
  assign vram_wdata = wword;

  // R3: memory writes only come from data-port writes
  assert_we_from_data_R3: assert property (@(posedge clk) disable iff (rst)
    vram_we |-> (bus_req && bus_we && bus_reg == 2'd1));

  // R6: an even-byte data write puts the same byte in both halves
  assert_byte_double_R6: assert property (@(posedge clk) disable iff (rst)
    (vram_we && bus_be == BE_EVEN) |->
      vram_wdata[DATA_W-1 -: BYTE_W] == vram_wdata[BYTE_W-1:0]);

  // R7: odd-byte or empty-lane writes have no effect
  assert_odd_dropped_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we && !bus_be[1]) |-> !vram_we);
  assert_odd_ptr_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we && !bus_be[1]) |=> $stable(vram_addr));

  // R11: read valid follows a read request by one cycle
  assert_rvalid_follows_R11: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_req && !bus_we));
  assert_rvalid_due_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we) |=> bus_rvalid);

endmodule

// File: tb/vram_port_bench.sv
`timescale 1ns/1ps
module vram_port_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_reg = 2'd0;
  logic [1:0]  bus_be = 2'b11;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;
  logic [15:0] vram_addr;
  logic [15:0] vram_wdata;
  logic        vram_we;
  logic [15:0] vram_rdata = 16'h0;

  int ntot = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vram_port u_vram_port (
    .clk(clk), .rst(rst),
    .bus_req(bus_req), .bus_we(bus_we), .bus_reg(bus_reg), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .vram_addr(vram_addr), .vram_wdata(vram_wdata), .vram_we(vram_we),
    .vram_rdata(vram_rdata)
  );

  // Environment memory: synchronous, read-first, one cycle latency
  logic [15:0] vmem [logic [15:0]];
  always @(posedge clk) begin
    vram_rdata <= vmem.exists(vram_addr) ? vmem[vram_addr] : 16'h0;
    if (vram_we) vmem[vram_addr] = vram_wdata;
  end

  // Reference model
  logic [15:0] ref_mem [logic [15:0]];
  logic [15:0] exp_ptr = 16'h0;
  logic [15:0] exp_stride = 16'h0;

  function automatic logic [15:0] ref_word(input logic [1:0] be, input logic [15:0] d);
    return (be == 2'b11) ? d : {d[15:8], d[15:8]};
  endfunction

  function automatic logic [15:0] ref_read(input logic [1:0] r);
    if (r == 2'd2) return exp_stride;
    if (r == 2'd3) return 16'h0;
    return ref_mem.exists(exp_ptr) ? ref_mem[exp_ptr] : 16'h0;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    ntot++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_wr(input logic [1:0] r, input logic [1:0] be,
                       input logic [15:0] d, input string tag);
    logic        ok;
    logic [15:0] w;
    ok = (be == 2'b11) || (be == 2'b10);
    w  = ref_word(be, d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_reg = r; bus_be = be; bus_wdata = d;
    #1;
    chk(tag, vram_addr, exp_ptr);
    chk(tag, {15'h0, vram_we}, {15'h0, ok && r == 2'd1});
    if (ok && r == 2'd1) chk(tag, vram_wdata, w);
    @(posedge clk); #1;
    bus_req = 1'b0; bus_we = 1'b0;
    if (ok) begin
      case (r)
        2'd0: exp_ptr = w;
        2'd1: begin ref_mem[exp_ptr] = w; exp_ptr = exp_ptr + exp_stride; end
        2'd2: exp_stride = w;
        default: ;
      endcase
    end
    chk("R11 no valid after write", {15'h0, bus_rvalid}, 16'h0);
    chk(tag, vram_addr, exp_ptr);
  endtask

  task automatic do_rd(input logic [1:0] r, input string tag);
    logic [15:0] e;
    e = ref_read(r);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_reg = r; bus_be = 2'b11;
    @(posedge clk); #1;
    bus_req = 1'b0;
    chk("R11 valid after read", {15'h0, bus_rvalid}, 16'h1);
    chk(tag, bus_rdata, e);
    chk("R4 pointer kept on read", vram_addr, exp_ptr);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      ntot++; nbad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 valid low in reset", {15'h0, bus_rvalid}, 16'h0);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1 pointer zero", vram_addr, 16'h0);
    chk("R1 valid low", {15'h0, bus_rvalid}, 16'h0);
    do_rd(2'd2, "R1 stride zero");

    // Pointer and stride load
    do_wr(2'd0, 2'b11, 16'h1234, "R2 pointer load");
    do_wr(2'd2, 2'b11, 16'h0003, "R5 stride load");
    do_rd(2'd2, "R5 stride readback");

    // Back-to-back data writes with positive stride
    do_wr(2'd1, 2'b11, 16'hA001, "R3 data write");
    do_wr(2'd1, 2'b11, 16'hA002, "R8 second write");
    do_wr(2'd1, 2'b11, 16'hA003, "R8 third write");
    chk("R8 pointer after three", vram_addr, 16'h123D);
    do_wr(2'd0, 2'b11, 16'h1237, "R2 pointer reload");
    do_rd(2'd1, "R4 read via data port");
    do_rd(2'd0, "R4 read via pointer reg");
    do_rd(2'd1, "R4 repeated read same cell");

    // Negative stride wrapping below zero
    do_wr(2'd0, 2'b11, 16'h0001, "R2 pointer near zero");
    do_wr(2'd2, 2'b11, 16'hFFFE, "R9 negative stride");
    do_wr(2'd1, 2'b11, 16'h5A5A, "R9 write at 1");
    chk("R9 wrap below zero", vram_addr, 16'hFFFF);
    do_wr(2'd1, 2'b11, 16'h6B6B, "R9 write at FFFF");
    chk("R9 pointer FFFD", vram_addr, 16'hFFFD);
    do_wr(2'd0, 2'b11, 16'hFFFF, "R2 pointer top");
    do_rd(2'd1, "R9 read at FFFF");
    do_wr(2'd2, 2'b11, 16'h0001, "R5 stride one");
    do_wr(2'd1, 2'b11, 16'h7C7C, "R9 write wraps up");
    chk("R9 wrap above FFFF", vram_addr, 16'h0000);

    // Zero stride keeps the pointer
    do_wr(2'd2, 2'b11, 16'h0000, "R5 stride zero");
    do_wr(2'd1, 2'b11, 16'h1111, "R3 zero stride write");
    do_wr(2'd1, 2'b11, 16'h2222, "R3 zero stride overwrite");
    do_rd(2'd1, "R3 last write wins");

    // Byte lanes
    do_wr(2'd0, 2'b10, 16'h40FF, "R6 even byte pointer");
    chk("R6 pointer doubled", vram_addr, 16'h4040);
    do_wr(2'd1, 2'b10, 16'hC3AA, "R6 even byte data");
    do_rd(2'd1, "R6 doubled word stored");
    do_wr(2'd2, 2'b10, 16'h8155, "R6 even byte stride");
    do_rd(2'd2, "R6 stride doubled");
    do_wr(2'd1, 2'b01, 16'hDEAD, "R7 odd byte data");
    do_wr(2'd0, 2'b01, 16'hBEEF, "R7 odd byte pointer");
    do_wr(2'd2, 2'b00, 16'h0F0F, "R7 empty lanes stride");
    do_wr(2'd1, 2'b00, 16'h0F0F, "R7 empty lanes data");
    do_rd(2'd2, "R7 stride unchanged");
    do_rd(2'd1, "R7 cell unchanged");

    // Unmapped register
    do_wr(2'd3, 2'b11, 16'h9999, "R10 unmapped write");
    do_rd(2'd3, "R10 unmapped read");
    do_rd(2'd2, "R10 stride untouched");

    // Seeded random mix in a small window
    do_wr(2'd2, 2'b11, 16'h0001, "R5 random stride");
    for (int i = 0; i < 600; i++) begin
      logic [1:0]  r;
      logic [1:0]  be;
      logic [15:0] d;
      r  = 2'($urandom_range(0, 3));
      be = 2'($urandom_range(0, 3));
      d  = 16'($urandom);
      if (r == 2'd0) d = {4'h3, 4'h3, 4'h0, d[3:0]};
      if (r == 2'd2) d = (d[15]) ? 16'hFFFD : {8'h00, 6'h0, d[1:0]};
      if ($urandom_range(0, 2) == 0) do_rd(r, "R4 random read");
      else do_wr(r, be, d, "R3 random write");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end

endmodule